// File: doc/BRIEF.md
# Two-Wire Serial Slave with Auto-Increment Pointer

This block is a slave on a two-wire serial bus (clock line SCL, data line SDA). It gives a bus master access to a small byte-wide memory through an internal address pointer. Both bus lines are synchronized to a fast system clock. The block detects START, repeated START and STOP conditions and answers a single fixed 7-bit device address. It pulls SDA low only through an open-drain enable and never drives it high.

Four transfers are supported:
- A write whose first byte loads the pointer.
- Sequential writes, where each further byte lands at the pointer and the pointer then steps forward.
- A random read: a pointer-setting write, then a repeated START with the read bit set.
- A current-address read, which starts wherever the pointer was left.

The pointer survives from one transaction to the next. During reads it advances only when the master acknowledges a byte. The memory itself sits outside the block, behind a plain synchronous port made of address, write data, write strobe and read data.

Top module: `twire_ptr_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins reception of a device-address byte from any state, including a repeated START. A STOP (SDA rising while SCL is high) releases SDA and returns the block to idle.
- R2: The address byte is received MSB first: seven address bits, then the direction bit (0 = write, 1 = read). When the seven bits equal 1101000, the block acknowledges by holding SDA low for the ninth clock.
- R3: Any other address gets no acknowledge. Until the next START or STOP, SDA stays released, no memory write occurs and the pointer keeps its value.
- R4: In a write, the first byte after the address is acknowledged and loads the pointer. Only its low 6 bits are used; bits 7:6 are ignored.
- R5: Each later byte of a write is acknowledged and stored at the pointer. The pointer then increments at the end of that acknowledge clock, wrapping from 63 to 0.
- R6: In a read, the byte at the pointer is shifted out MSB first. Each bit is driven after SCL falls and held through the following high phase.
- R7: When the master acknowledges a read byte, the pointer increments (63 wraps to 0) and the byte at the new pointer is sent next.
- R8: When the master does not acknowledge a read byte, the block releases SDA, leaves the pointer unchanged and sends nothing more until START or STOP.
- R9: The pointer is kept across transactions. A read that starts directly with the direction bit set begins at the stored pointer.
- R10: The SDA enable changes only while SCL is low. The only exception is the forced release on a START or STOP.
- R11: After reset, SDA is released, the pointer is 0 and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| memAddr | output | 6 | Memory address, equal to the pointer |
| memWdata | output | 8 | Byte to write |
| memWe | output | 1 | One-cycle write strobe |
| memRdata | input | 8 | Read data, valid one cycle after memAddr settles |

## Verification
A corrupted pointer shows up on the very next read as a byte from the wrong location. It also shows up on the next write as a byte landing at the wrong address. Either way it appears within one transfer, so the scenarios alternate writes with reads that start from the retained pointer. A decoder stuck in the wrong state shows up within one bit time as a missing or spurious acknowledge, or as SDA driven in a bit slot that belongs to the master. A port monitor watches every change of the SDA enable against the SCL level.

// File: rtl/twire_pkg.sv
package twire_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_RACK, ST_RACKED, ST_SKIP
  } twState_e;

  typedef enum logic [1:0] {K_DEV, K_WORD, K_DATA} rxKind_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic              loadPtr;
    logic              incPtr;
    logic              wrEn;
    logic [BYTE_W-1:0] data;
  } dpCmd_t;
endpackage

// File: rtl/twire_sync.sv
module twire_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/twire_ctrl.sv
module twire_ctrl
  import twire_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1101000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] memRdata,
  output dpCmd_t            cmd,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic sclS, sdaS, sclPrev, sdaPrev;
  logic busStart, busStop, sclRise, sclFall;
  twState_e state;
  rxKind_e  kind;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxSh, txSh;
  logic rdMode;

  twire_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSclSync (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));
  twire_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSdaSync (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign busStart = sclS && sclPrev && sdaPrev && !sdaS;
  assign busStop  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      kind   <= K_DEV;
      bitCnt <= '0;
      rxSh   <= '0;
      txSh   <= '0;
      rdMode <= 1'b0;
      sdaOe  <= 1'b0;
      cmd    <= '0;
    end else begin
      cmd <= '0;
      if (busStart) begin
        state  <= ST_RX;
        kind   <= K_DEV;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (busStop) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (sclRise) begin
            rxSh   <= {rxSh[BYTE_W-2:0], sdaS};
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) state <= ST_RXEND;
          end
          ST_RXEND: if (sclFall) begin
            case (kind)
              K_DEV: begin
                if (rxSh[7:1] == DEV_ADDR) begin
                  rdMode <= rxSh[0];
                  sdaOe  <= 1'b1;
                  state  <= ST_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end
              K_WORD: begin
                cmd.loadPtr <= 1'b1;
                cmd.data    <= rxSh;
                sdaOe       <= 1'b1;
                state       <= ST_ACK;
              end
              default: begin
                cmd.wrEn <= 1'b1;
                cmd.data <= rxSh;
                sdaOe    <= 1'b1;
                state    <= ST_ACK;
              end
            endcase
          end
          ST_ACK: if (sclFall) begin
            bitCnt <= '0;
            if (kind == K_DEV && rdMode) begin
              txSh  <= memRdata;
              sdaOe <= !memRdata[BYTE_W-1];
              state <= ST_TX;
            end else begin
              sdaOe <= 1'b0;
              state <= ST_RX;
              if (kind == K_DEV) kind <= K_WORD;
              else begin
                if (kind == K_DATA) cmd.incPtr <= 1'b1;
                kind <= K_DATA;
              end
            end
          end
          ST_TX: if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              sdaOe <= 1'b0;
              state <= ST_RACK;
            end else begin
              txSh   <= {txSh[BYTE_W-2:0], 1'b0};
              sdaOe  <= !txSh[BYTE_W-2];
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_RACK: if (sclRise) begin
            if (sdaS) state <= ST_SKIP;
            else begin
              cmd.incPtr <= 1'b1;
              state      <= ST_RACKED;
            end
          end
          ST_RACKED: if (sclFall) begin
            txSh   <= memRdata;
            sdaOe  <= !memRdata[BYTE_W-1];
            bitCnt <= '0;
            state  <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end

  // R10: enable moves only with SCL low, except forced release on START/STOP
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> (!sclS || $past(busStart || busStop)));

  // R3: while ignoring the bus nothing is driven or strobed
  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> (!sdaOe && !cmd.wrEn && !cmd.loadPtr && !cmd.incPtr));

  // R2: acknowledge slot always holds SDA low
  p_ack_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK) |-> sdaOe);

  // R8: master NACK releases the line and stops transmission
  p_nack_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && sclRise && sdaS && !busStart && !busStop)
      |=> (state == ST_SKIP && !sdaOe && !cmd.incPtr));
endmodule

// File: rtl/twire_dp.sv
module twire_dp
  import twire_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe
);
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rstN)            ptr <= '0;
    else if (cmd.loadPtr) ptr <= cmd.data[ADDR_W-1:0];
    else if (cmd.incPtr)  ptr <= ptr + 1'b1;
  end

  assign memAddr  = ptr;
  assign memWdata = cmd.data;
  assign memWe    = cmd.wrEn;

  // R5: strobes from control never overlap
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({cmd.loadPtr, cmd.incPtr, cmd.wrEn}) <= 1);

  // R9: pointer holds unless loaded or stepped
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.loadPtr && !cmd.incPtr) |=> $stable(ptr));

  // R7: stepping from the top address wraps to zero
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.incPtr && ptr == '1) |=> (ptr == '0));
endmodule

// File: rtl/twire_ptr_slave.sv
module twire_ptr_slave
  import twire_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1101000,
  parameter int         ADDR_W      = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe,
  input  logic [BYTE_W-1:0] memRdata
);
  dpCmd_t cmd;

  twire_ctrl #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .memRdata(memRdata), .cmd(cmd), .sdaOe(sdaOe));

  twire_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe));
endmodule

// File: tb/tb_twire_ptr_slave.sv
module tb_twire_ptr_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe, memWe;
  logic [5:0] memAddr;
  logic [7:0] memWdata, rdQ;
  logic sdaLine;
  assign sdaLine = sdaM & ~sdaOe;

  int total = 0;
  int bad = 0;
  int wrCount = 0;
  int sclBad = 0;
  logic prevOe = 1'b0;
  logic [7:0] mem [64];

  twire_ptr_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(rdQ));

  function automatic logic [7:0] initVal(int i);
    return 8'(i * 3 + 1);
  endfunction

  initial for (int i = 0; i < 64; i++) mem[i] = initVal(i);

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr] <= memWdata;
      wrCount <= wrCount + 1;
    end
    rdQ <= mem[memAddr];
  end

  always @(negedge clk) begin
    if (rstN && sdaOe !== prevOe && sclM) sclBad++;
    prevOe <= sdaOe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic writeBit(logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    acked = !b;
  endtask

  task automatic recvByte(logic giveAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(!giveAck);
  endtask

  task automatic tReset();
    chk("R11 sdaOe", 32'(sdaOe), 0);
    chk("R11 memWe", 32'(memWe), 0);
    chk("R11 memAddr", 32'(memAddr), 0);
  endtask

  task automatic tWriteSeq();
    logic a;
    startCond();
    sendByte(8'hD0, a); chk("R2 addr ack", 32'(a), 1);
    sendByte(8'h05, a); chk("R4 word ack", 32'(a), 1);
    sendByte(8'h11, a); chk("R5 data ack", 32'(a), 1);
    sendByte(8'h22, a);
    sendByte(8'h33, a);
    stopCond();
    chk("R5 mem5", 32'(mem[5]), 32'h11);
    chk("R5 mem6", 32'(mem[6]), 32'h22);
    chk("R5 mem7", 32'(mem[7]), 32'h33);
  endtask

  task automatic tRandRead();
    logic a;
    logic [7:0] v;
    startCond();
    sendByte(8'hD0, a);
    sendByte(8'h05, a);
    startCond();
    sendByte(8'hD1, a); chk("R1 R2 restart read ack", 32'(a), 1);
    recvByte(1'b1, v); chk("R6 first byte", 32'(v), 32'h11);
    recvByte(1'b1, v); chk("R7 second byte", 32'(v), 32'h22);
    recvByte(1'b0, v); chk("R7 third byte", 32'(v), 32'h33);
    chk("R8 released after nack", 32'(sdaOe), 0);
    stopCond();
  endtask

  task automatic tCurRead();
    logic a;
    logic [7:0] v;
    startCond();
    sendByte(8'hD1, a); chk("R9 cur read ack", 32'(a), 1);
    recvByte(1'b1, v); chk("R8 R9 no step on nack", 32'(v), 32'h33);
    recvByte(1'b0, v); chk("R7 after ack", 32'(v), 32'(initVal(8)));
    stopCond();
  endtask

  task automatic tUpperWrap();
    logic a;
    startCond();
    sendByte(8'hD0, a);
    sendByte(8'hFE, a); chk("R4 word ack hi bits", 32'(a), 1);
    sendByte(8'h9A, a);
    sendByte(8'hE1, a);
    sendByte(8'h2B, a);
    stopCond();
    chk("R4 upper bits ignored", 32'(mem[62]), 32'h9A);
    chk("R5 mem63", 32'(mem[63]), 32'hE1);
    chk("R5 wrap to 0", 32'(mem[0]), 32'h2B);
  endtask

  task automatic tWrapRead();
    logic a;
    logic [7:0] v;
    startCond();
    sendByte(8'hD0, a);
    sendByte(8'h3F, a);
    startCond();
    sendByte(8'hD1, a);
    recvByte(1'b1, v); chk("R6 byte at 63", 32'(v), 32'hE1);
    recvByte(1'b0, v); chk("R7 read wrap", 32'(v), 32'h2B);
    stopCond();
  endtask

  task automatic tMismatch();
    logic a;
    logic [7:0] v;
    int w0;
    w0 = wrCount;
    startCond();
    sendByte(8'h50, a); chk("R3 no addr ack", 32'(a), 0);
    sendByte(8'h07, a); chk("R3 no byte ack", 32'(a), 0);
    sendByte(8'h44, a);
    stopCond();
    chk("R3 no writes", 32'(wrCount - w0), 0);
    startCond();
    sendByte(8'hD1, a);
    recvByte(1'b0, v); chk("R3 R9 pointer kept", 32'(v), 32'h2B);
    stopCond();
  endtask

  task automatic tAbort();
    logic a;
    logic [7:0] v;
    startCond();
    sendByte(8'hD0, a);
    stopCond();
    startCond();
    sendByte(8'hD0, a); chk("R1 after stop ack", 32'(a), 1);
    sendByte(8'h10, a);
    sendByte(8'h77, a);
    stopCond();
    chk("R1 write after abort", 32'(mem[16]), 32'h77);
    startCond();
    sendByte(8'hA1, a); chk("R3 other read addr", 32'(a), 0);
    startCond();
    sendByte(8'hD1, a); chk("R1 restart after mismatch", 32'(a), 1);
    recvByte(1'b0, v); chk("R5 R9 pointer after write", 32'(v), 32'(initVal(17)));
    stopCond();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tWriteSeq();
    tRandRead();
    tCurRead();
    tUpperWrap();
    tWrapRead();
    tMismatch();
    tAbort();
    chk("R10 oe changed with scl high", 32'(sclBad), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule